// File: doc/BRIEF.md
# Triangle Waveform Step Sequencer

This block produces the 4-bit amplitude steps of a triangle-wave tone voice. An 11-bit down-counting period timer advances on each enabled tick. Each time it expires it reloads the programmed period and raises a one-cycle terminal pulse. That pulse steps a 5-bit counter that only counts upward. The output takes the counter's four low bits, inverts them while the counter's top bit is clear and passes them through while it is set. The result is a symmetric ramp: it falls from 15 to 0, holds 0 for two steps, rises back to 15 and holds 15 for two steps. One full waveform therefore spans 32 timer expirations.

Two gate inputs come from the voice's duration logic, which lies outside this block: a length-count-zero flag and a linear-count-zero flag. While either flag is high, the step counter keeps its present value and is not cleared. The timer keeps running during that time. The 4-bit output goes straight to a DAC.

Top module: `tri_wave_stepper`

## Requirements
- R1: A synchronous active-low reset clears the step counter to 0 and the period timer to 0, so `step_o` reads 15 after reset.
- R2: `step_o` equals 15 minus the counter value for counter values 0..15, and the counter value minus 16 for values 16..31. Over 32 advances the output runs 15,14,...,1,0,0,1,...,14,15.
- R3: The step counter advances by exactly one on each terminal pulse that is not gated, and it wraps from 31 to 0.
- R4: On an enabled tick with the timer at 0, the timer loads `period_i` and a terminal pulse occurs. Otherwise an enabled tick decrements the timer. A period P therefore gives one pulse per P+1 enabled ticks, and the first enabled tick after reset produces a pulse.
- R5: A change of `period_i` does not alter a count already in progress. It is used only at the next reload.
- R6: When `tick_en_i` is low, neither the timer nor the step counter changes, however many cycles pass.
- R7: While `len_zero_i` is high, the step counter holds its value through terminal pulses and the timer keeps counting. Advancing resumes from the held value.
- R8: While `lin_zero_i` is high, the step counter holds its value in the same way as for R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en_i | input | 1 | Clock enable for the period timer |
| period_i | input | 11 | Reload value of the period timer |
| len_zero_i | input | 1 | Length count is zero: freeze the step counter |
| lin_zero_i | input | 1 | Linear count is zero: freeze the step counter |
| step_o | output | 4 | Triangle amplitude step for the DAC |

## Verification
On every cycle the assertions check four things: the mapping from counter value to output, the single-step advance on ungated pulses, the freeze under each gate and under a low enable, and the reload of the period after a pulse. The bench scenarios cover what the assertions cannot show on their own. These are the tick counts between steps for several periods, a period change made mid-count that takes effect only at the next reload, a gated run that resumes from its held value, the two repeated endpoints and the wrap across a full 64-step sweep, and the largest period.

// File: rtl/tri_wave_pkg.sv
package tri_wave_pkg;
    localparam int TRI_PERIOD_W = 11;
    localparam int TRI_STEP_W   = 5;
endpackage

// File: rtl/tri_period_timer.sv
module tri_period_timer #(
    parameter int PERIOD_W = tri_wave_pkg::TRI_PERIOD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                tc_o,
    output logic [PERIOD_W-1:0] count_o
);
    localparam logic [PERIOD_W-1:0] CNT_ONE = PERIOD_W'(1);

    typedef struct packed {
        logic [PERIOD_W-1:0] count;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic tc_d;

    always_comb begin
        tmr_d = tmr_q;
        tc_d  = 1'b0;
        if (tick_en_i) begin
            if (tmr_q.count == '0) begin
                tmr_d.count = period_i;
                tc_d        = 1'b1;
            end else begin
                tmr_d.count = tmr_q.count - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign tc_o    = tc_d;
    assign count_o = tmr_q.count;
endmodule

// File: rtl/tri_step_counter.sv
module tri_step_counter #(
    parameter int STEP_W = tri_wave_pkg::TRI_STEP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              hold_i,
    output logic [STEP_W-1:0] cnt_o
);
    localparam logic [STEP_W-1:0] STEP_ONE = STEP_W'(1);

    typedef struct packed {
        logic [STEP_W-1:0] cnt;
    } stp_t;

    stp_t stp_d, stp_q;

    always_comb begin
        stp_d = stp_q;
        if (adv_i && !hold_i) stp_d.cnt = stp_q.cnt + STEP_ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stp_q <= '0;
        else        stp_q <= stp_d;
    end

    assign cnt_o = stp_q.cnt;
endmodule

// File: rtl/tri_step_shaper.sv
module tri_step_shaper #(
    parameter int STEP_W = tri_wave_pkg::TRI_STEP_W,
    localparam int OUT_W = STEP_W - 1
) (
    input  logic [STEP_W-1:0] cnt_i,
    output logic [OUT_W-1:0]  step_o
);
    // Each low bit is XNORed with the top bit: inverted on the falling half.
    for (genvar b = 0; b < OUT_W; b++) begin : g_fold
        assign step_o[b] = ~(cnt_i[b] ^ cnt_i[STEP_W-1]);
    end
endmodule

// File: rtl/tri_wave_stepper.sv
module tri_wave_stepper #(
    parameter int PERIOD_W = tri_wave_pkg::TRI_PERIOD_W,
    parameter int STEP_W   = tri_wave_pkg::TRI_STEP_W,
    localparam int OUT_W   = STEP_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                len_zero_i,
    input  logic                lin_zero_i,
    output logic [OUT_W-1:0]    step_o
);
    logic                tc_w;
    logic [PERIOD_W-1:0] tmr_cnt_w;
    logic [STEP_W-1:0]   cnt_w;
    logic                hold_w;

    assign hold_w = len_zero_i | lin_zero_i;

    tri_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en_i (tick_en_i),
        .period_i  (period_i),
        .tc_o      (tc_w),
        .count_o   (tmr_cnt_w)
    );

    tri_step_counter #(.STEP_W(STEP_W)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (tc_w),
        .hold_i (hold_w),
        .cnt_o  (cnt_w)
    );

    tri_step_shaper #(.STEP_W(STEP_W)) u_shaper (
        .cnt_i  (cnt_w),
        .step_o (step_o)
    );
endmodule

// File: rtl/tri_wave_stepper_chk.sv
module tri_wave_stepper_chk #(
    parameter int PERIOD_W = 11,
    parameter int STEP_W   = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_en_i,
    input logic [PERIOD_W-1:0] period_i,
    input logic                len_zero_i,
    input logic                lin_zero_i,
    input logic [STEP_W-2:0]   step_o,
    input logic                tc,
    input logic [STEP_W-1:0]   cnt,
    input logic [PERIOD_W-1:0] tmr_cnt
);
    localparam int HALF = 2 ** (STEP_W - 1);

    p_reset_top_r1: assert property (@(posedge clk)
        !rst_n |=> (int'(step_o) == HALF - 1));

    p_ramp_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(step_o) == ((int'(cnt) < HALF) ? (HALF - 1 - int'(cnt)) : (int'(cnt) - HALF)));

    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !len_zero_i && !lin_zero_i) |=> (cnt == $past(cnt) + STEP_W'(1)));

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> (tmr_cnt == $past(period_i)));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en_i |=> ($stable(tmr_cnt) && $stable(cnt)));

    p_len_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        len_zero_i |=> $stable(cnt));

    p_lin_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lin_zero_i |=> $stable(cnt));
endmodule

bind tri_wave_stepper tri_wave_stepper_chk #(
    .PERIOD_W (PERIOD_W),
    .STEP_W   (STEP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en_i  (tick_en_i),
    .period_i   (period_i),
    .len_zero_i (len_zero_i),
    .lin_zero_i (lin_zero_i),
    .step_o     (step_o),
    .tc         (tc_w),
    .cnt        (cnt_w),
    .tmr_cnt    (tmr_cnt_w)
);

// File: tb/tri_wave_stepper_bench.sv
module tri_wave_stepper_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en_i = 1'b0;
    logic [10:0] period_i = '0;
    logic        len_zero_i = 1'b0;
    logic        lin_zero_i = 1'b0;
    logic [3:0]  step_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_wave_stepper u_tri_wave_stepper (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en_i  (tick_en_i),
        .period_i   (period_i),
        .len_zero_i (len_zero_i),
        .lin_zero_i (lin_zero_i),
        .step_o     (step_o)
    );

    typedef struct packed {
        logic [10:0] period;
        logic [11:0] ticks;
        logic        lz;
        logic        nz;
        logic [3:0]  exp;
    } vec_t;

    // Walked in order from reset; each row applies ticks then checks step_o.
    localparam vec_t VECS [13] = '{
        '{11'd2, 12'd1,  1'b0, 1'b0, 4'd14}, // R4 first tick pulses
        '{11'd2, 12'd3,  1'b0, 1'b0, 4'd13}, // R4 P+1 ticks per step
        '{11'd2, 12'd6,  1'b0, 1'b0, 4'd11}, // R3
        '{11'd2, 12'd6,  1'b1, 1'b0, 4'd11}, // R7 frozen
        '{11'd2, 12'd6,  1'b0, 1'b1, 4'd11}, // R8 frozen
        '{11'd5, 12'd3,  1'b0, 1'b0, 4'd10}, // R5/R7 timer ran while gated
        '{11'd5, 12'd6,  1'b0, 1'b0, 4'd9},  // R5 new period in force
        '{11'd0, 12'd1,  1'b0, 1'b0, 4'd9},  // R5 count not cut short
        '{11'd0, 12'd5,  1'b0, 1'b0, 4'd8},  // R5
        '{11'd0, 12'd1,  1'b0, 1'b0, 4'd7},  // R4 period zero
        '{11'd0, 12'd8,  1'b0, 1'b0, 4'd0},  // R2 bottom repeated
        '{11'd0, 12'd1,  1'b0, 1'b0, 4'd1},  // R2 rising
        '{11'd0, 12'd15, 1'b0, 1'b0, 4'd15}  // R3 wrap to start
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en_i = 1'b1;
            @(posedge clk);
        end
        @(negedge clk);
        tick_en_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        int idx;
        int exp_v;
        do_reset();
        check("R1 reset output", int'(step_o), 15);

        for (int v = 0; v < 13; v++) begin
            period_i   = VECS[v].period;
            len_zero_i = VECS[v].lz;
            lin_zero_i = VECS[v].nz;
            run_ticks(int'(VECS[v].ticks));
            check($sformatf("R3 vector %0d", v), int'(step_o), int'(VECS[v].exp));
        end
        len_zero_i = 1'b0;
        lin_zero_i = 1'b0;

        // R1: reset in mid-waveform
        period_i = 11'd0;
        run_ticks(5);
        do_reset();
        check("R1 mid-run reset", int'(step_o), 15);

        // R2/R3: two full sweeps at period 0
        idx = 0;
        for (int s = 0; s < 64; s++) begin
            run_ticks(1);
            idx   = (idx + 1) % 32;
            exp_v = (idx < 16) ? (15 - idx) : (idx - 16);
            check("R2 ramp sweep", int'(step_o), exp_v);
        end

        // R6: idle enable freezes timer and counter
        do_reset();
        period_i = 11'd3;
        run_ticks(1);
        check("R6 before idle", int'(step_o), 14);
        repeat (20) @(negedge clk);
        check("R6 idle output", int'(step_o), 14);
        run_ticks(3);
        check("R6 timer held", int'(step_o), 14);
        run_ticks(1);
        check("R6 resumes", int'(step_o), 13);

        // R4: largest period
        do_reset();
        period_i = 11'd2047;
        run_ticks(1);
        check("R4 max first", int'(step_o), 14);
        run_ticks(2047);
        check("R4 max no step", int'(step_o), 14);
        run_ticks(1);
        check("R4 max step", int'(step_o), 13);

        // R7/R8: both gates, then resume from held value
        lin_zero_i = 1'b1;
        len_zero_i = 1'b1;
        period_i   = 11'd0;
        run_ticks(2048);
        check("R7 both gates", int'(step_o), 13);
        len_zero_i = 1'b0;
        lin_zero_i = 1'b0;
        run_ticks(1);
        check("R8 resume", int'(step_o), 12);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule